// File: doc/BRIEF.md
# Inbound Mailbox Register Interface

This block is the processor-facing side of a mailbox. A separate producer pushes 32-bit response words into an inbound FIFO. The processor drains that FIFO through a small register window on a simple valid/write/address/data port. The window is 1 KB, but only the low 8 bits of the byte offset are decoded, so the register set repeats every 256 bytes. The block also reports the fill state of a second, outbound FIFO. That FIFO lives elsewhere, and only its entry count comes in here.

A read from the pop range removes the oldest word. A read from the peek register returns the oldest word without removing it. A read of an empty FIFO does not stall: it returns the all-ones sentinel and sets a sticky error bit. One level interrupt output is high while the FIFO holds data and the processor has enabled the interrupt. The config register holds three kinds of bit:
- the interrupt enable, which software writes;
- a pending bit, which hardware drives;
- three sticky error bits, which any full-width write to config clears.

Accesses are word-aligned. Only full 32-bit accesses (`req_full` high) have any effect. A read response arrives one cycle after the request.

Top module: `mbox_regif`

## Requirements
- R1: After reset the FIFO is empty. Status (offset 0x98) reads 0x40000000, config (0x9C) reads 0, a peek (0x90) reads 0xFFFFFFFF and `irq` is low.
- R2: A full-width read at offsets 0x80, 0x84, 0x88 or 0x8C returns the oldest inbound word and removes it. Words come out in push order.
- R3: A pop read while the FIFO is empty returns 0xFFFFFFFF, removes nothing and sets config bit 10.
- R4: A read at 0x90 returns the oldest word and leaves the FIFO unchanged. With the FIFO empty it returns 0xFFFFFFFF, including after a full fill-and-drain cycle.
- R5: Status at 0x98 is formatted as follows: bit 31 is set when the FIFO holds DEPTH words, bit 30 is set when it holds none, bits 7:0 carry the entry count and all other bits are 0.
- R6: A read at 0xB8 returns the same status format, computed from the outbound count input `ob_count`.
- R7: A full-width write to config changes only bit 0, the interrupt enable. It is taken from write-data bit 0.
- R8: Config bit 4 reads 1 exactly when the inbound FIFO is not empty.
- R9: `irq` is high exactly when config bits 4 and 0 are both 1. It follows each access on the next cycle.
- R10: Two events set sticky config bits. A push while the FIFO is full is dropped and sets bit 9. A pulse on `in_noowner` sets bit 8. Any full-width write to config clears bits 8, 9 and 10, unless an event in the same cycle sets a bit again.
- R11: Offset 0x94 and every unsupported offset read as 0, and writes to them change nothing.
- R12: An access with `req_full` low has no effect. A read of this kind returns 0.
- R13: Offset bits above bit 7 are ignored, so a read at 0x184 pops like a read at 0x84.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | Access is a full 32-bit word |
| req_addr | input | 10 | Byte offset within the 1 KB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| in_push | input | 1 | Producer pushes `in_data` into the inbound FIFO |
| in_data | input | 32 | Inbound word |
| in_noowner | input | 1 | Pulse: a read was made by a non-owner |
| in_full | output | 1 | Inbound FIFO holds DEPTH words |
| ob_count | input | 4 | Outbound FIFO entry count (width $clog2(DEPTH+1)) |
| irq | output | 1 | Data-waiting interrupt |

## Verification
The checker module watches a set of rules on every cycle:
- the entry count never exceeds DEPTH;
- `irq` is never high while the FIFO is empty;
- a push into a full FIFO raises the overflow bit;
- an empty pop answers with the sentinel and raises the underflow bit;
- a config write clears the error bits;
- offset 0x94 reads 0;
- a partial access never moves the count.

Some behaviour only the bench scenarios can show: FIFO ordering through pointer wrap, peek returning the head without removing it, the exact status and config word layouts, address aliasing above bit 7, and the cases where a write must leave state unchanged.

// File: rtl/mbox_pkg.sv
// Package: constants and helpers shared by the mailbox register interface.
// Assumes word-aligned offsets; only offset bits 7:2 select a register.
package mbox_pkg;

    localparam logic [31:0] MBOX_SENTINEL = 32'hFFFF_FFFF;

    // Word index (offset >> 2) of each register.
    localparam logic [5:0] WIDX_POP_HI  = 6'h23;  // 0x8C, top of pop range
    localparam logic [5:0] WIDX_POP_LO  = 6'h20;  // 0x80, bottom of pop range
    localparam logic [5:0] WIDX_PEEK    = 6'h24;  // 0x90
    localparam logic [5:0] WIDX_SENDER  = 6'h25;  // 0x94
    localparam logic [5:0] WIDX_STATUS  = 6'h26;  // 0x98
    localparam logic [5:0] WIDX_CONFIG  = 6'h27;  // 0x9C
    localparam logic [5:0] WIDX_OBSTAT  = 6'h2E;  // 0xB8

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_POP,
        SEL_PEEK,
        SEL_SENDER,
        SEL_STATUS,
        SEL_CONFIG,
        SEL_OBSTAT
    } reg_sel_e;

    // Build a status word: full flag, empty flag, 8-bit entry count.
    function automatic logic [31:0] status_word(input logic full,
                                                input logic empty,
                                                input logic [7:0] level);
        return {full, empty, 22'b0, level};
    endfunction

endpackage

// File: rtl/mbox_decode.sv
// Module: mbox_decode
// Turns one register request into a register select plus read/write strobes.
// Assumes: only offset bits 7:0 arrive here, and the access is word-aligned.
// Partial-width accesses produce no strobe.
module mbox_decode
    import mbox_pkg::*;
(
    input  logic       valid,
    input  logic       write,
    input  logic       full,
    input  logic [7:0] off,
    output reg_sel_e   sel,
    output logic       rd_stb,
    output logic       wr_stb
);

    logic [5:0] widx;
    assign widx = off[7:2];

    // Map the word index onto a register select.
    always_comb begin
        if (widx >= WIDX_POP_LO && widx <= WIDX_POP_HI) sel = SEL_POP;
        else if (widx == WIDX_PEEK)                      sel = SEL_PEEK;
        else if (widx == WIDX_SENDER)                    sel = SEL_SENDER;
        else if (widx == WIDX_STATUS)                    sel = SEL_STATUS;
        else if (widx == WIDX_CONFIG)                    sel = SEL_CONFIG;
        else if (widx == WIDX_OBSTAT)                    sel = SEL_OBSTAT;
        else                                             sel = SEL_NONE;
    end

    // Only full-width requests produce strobes.
    assign rd_stb = valid && full && !write;
    assign wr_stb = valid && full &&  write;

endmodule

// File: rtl/mbox_fifo.sv
// Module: mbox_fifo
// Ring-buffer FIFO of DEPTH words.
// - Every slot holds the sentinel after reset, and a slot is reloaded with the
//   sentinel as soon as it is popped, so the head always reads the sentinel
//   when the FIFO is empty.
// - A push while full is dropped and flagged.
// - A pop while empty does nothing and is flagged.
// Assumes 1 <= DEPTH <= 255.
module mbox_fifo
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ev_overflow,
    output logic          ev_underflow
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] slot [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          push_ok, pop_ok;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full         = (count == CW'(DEPTH));
    assign empty        = (count == '0);
    assign push_ok      = push && !full;
    assign pop_ok       = pop && !empty;
    assign ev_overflow  = push && full;
    assign ev_underflow = pop && empty;
    assign head         = slot[rd_ptr];

    // Slot storage: write on push, reload the sentinel on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= MBOX_SENTINEL;
        end else begin
            if (pop_ok)  slot[rd_ptr] <= MBOX_SENTINEL;
            if (push_ok) slot[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

endmodule

// File: rtl/mbox_cfg.sv
// Module: mbox_cfg
// Config register.
// - Holds the data-waiting interrupt enable and three sticky error bits.
// - Drives the pending bit from the FIFO occupancy.
// - Produces the interrupt.
// A config write clears the error bits; an error event in the same cycle still
// sets its bit.
module mbox_cfg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        wr_enable_bit,
    input  logic        not_empty,
    input  logic        ev_noowner,
    input  logic        ev_overflow,
    input  logic        ev_underflow,
    output logic [31:0] cfg_word,
    output logic [2:0]  err,
    output logic        irq
);

    logic irq_en;

    // Interrupt enable: only config writes touch it.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_en <= 1'b0;
        else if (cfg_wr) irq_en <= wr_enable_bit;
    end

    // Sticky errors: clear on config write, set on events (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) err <= '0;
        else        err <= (cfg_wr ? 3'b000 : err)
                           | {ev_underflow, ev_overflow, ev_noowner};
    end

    // Register layout: errors at 10:8, pending at 4, enable at 0.
    assign cfg_word = {21'b0, err, 3'b0, not_empty, 3'b0, irq_en};
    assign irq      = not_empty && irq_en;

endmodule

// File: rtl/mbox_regif.sv
// Module: mbox_regif (top)
// Processor-side register window of the inbound mailbox.
// - Decodes offset bits 7:0 only.
// - Pops or peeks the inbound FIFO.
// - Reports inbound and outbound status.
// - Hosts the config register.
// Read data is registered and returned one cycle after the request.
// Assumes word-aligned offsets and 1 <= DEPTH <= 255.
module mbox_regif
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 10,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_full,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    input  logic          in_push,
    input  logic [31:0]   in_data,
    input  logic          in_noowner,
    output logic          in_full,
    input  logic [CW-1:0] ob_count,
    output logic          irq
);

    reg_sel_e      sel;
    logic          rd_stb, wr_stb;
    logic          pop_req, cfg_wr;
    logic [31:0]   head, cfg_word, rd_mux;
    logic [CW-1:0] in_cnt;
    logic          in_empty;
    logic          ev_over, ev_under;
    logic [2:0]    cfg_err;
    logic          unused_bits;

    assign unused_bits = ^{req_addr[AW-1:8], req_wdata[31:1]};

    mbox_decode u_dec (
        .valid  (req_valid),
        .write  (req_write),
        .full   (req_full),
        .off    (req_addr[7:0]),
        .sel    (sel),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb)
    );

    assign pop_req = rd_stb && (sel == SEL_POP);
    assign cfg_wr  = wr_stb && (sel == SEL_CONFIG);

    mbox_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (in_push),
        .push_data    (in_data),
        .pop          (pop_req),
        .head         (head),
        .count        (in_cnt),
        .full         (in_full),
        .empty        (in_empty),
        .ev_overflow  (ev_over),
        .ev_underflow (ev_under)
    );

    mbox_cfg u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .wr_enable_bit (req_wdata[0]),
        .not_empty     (!in_empty),
        .ev_noowner    (in_noowner),
        .ev_overflow   (ev_over),
        .ev_underflow  (ev_under),
        .cfg_word      (cfg_word),
        .err           (cfg_err),
        .irq           (irq)
    );

    // Select read data from the current (pre-access) state.
    always_comb begin
        unique case (sel)
            SEL_POP:    rd_mux = in_empty ? MBOX_SENTINEL : head;
            SEL_PEEK:   rd_mux = head;
            SEL_STATUS: rd_mux = status_word(in_full, in_empty, 8'(in_cnt));
            SEL_CONFIG: rd_mux = cfg_word;
            SEL_OBSTAT: rd_mux = status_word(ob_count >= CW'(DEPTH),
                                             ob_count == '0, 8'(ob_count));
            default:    rd_mux = 32'h0;
        endcase
    end

    // Register the read response; partial reads answer 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= rd_stb ? rd_mux : 32'h0;
        end
    end

endmodule

// File: rtl/mbox_regif_chk.sv
// Module: mbox_regif_chk
// Cycle-level rules for mbox_regif, attached with bind.
module mbox_regif_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_full,
    input logic [7:0]    off,
    input logic          in_push,
    input logic          in_noowner,
    input logic          in_full,
    input logic          irq,
    input logic          rsp_valid,
    input logic [31:0]   rsp_rdata,
    input logic [CW-1:0] cnt,
    input logic [2:0]    err
);

    logic full_rd, full_wr;
    assign full_rd = req_valid && req_full && !req_write;
    assign full_wr = req_valid && req_full &&  req_write;

    // R5: occupancy never exceeds the depth.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R9: no interrupt without data.
    p_irq_has_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt != '0);

    // R10: a push while full raises the overflow bit.
    p_overflow_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_push && in_full) |=> err[1]);

    // R3: an empty pop answers with the sentinel and raises the underflow bit.
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rd && off[7:4] == 4'h8 && cnt == '0)
            |=> (rsp_valid && rsp_rdata == 32'hFFFF_FFFF && err[2]));

    // R10: a config write with no concurrent event clears all errors.
    p_cfg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && off == 8'h9C && !in_push && !in_noowner) |=> err == 3'b000);

    // R11: offset 0x94 reads zero.
    p_sender_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rd && off == 8'h94) |=> rsp_rdata == 32'h0);

    // R12: a partial access never moves the count.
    p_partial_noeffect_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_full && !in_push) |=> $stable(cnt));

endmodule

bind mbox_regif mbox_regif_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_full   (req_full),
    .off        (req_addr[7:0]),
    .in_push    (in_push),
    .in_noowner (in_noowner),
    .in_full    (in_full),
    .irq        (irq),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .cnt        (in_cnt),
    .err        (cfg_err)
);

// File: tb/mbox_regif_tb.sv
// Scoreboard bench: read tasks queue the expected word, and a monitor compares
// each response as it appears.
`timescale 1ns/1ps
module mbox_regif_tb;

    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write, req_full;
    logic [9:0]    req_addr;
    logic [31:0]   req_wdata;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          in_push, in_noowner, in_full, irq;
    logic [31:0]   in_data;
    logic [CW-1:0] ob_count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    mbox_regif #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_full(req_full),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .in_push(in_push), .in_data(in_data), .in_noowner(in_noowner),
        .in_full(in_full), .ob_count(ob_count), .irq(irq)
    );

    // Compare one observed value with its expected value.
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: match each read response against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("unexpected response", rsp_rdata, 32'hDEAD_0000);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // Issue a read and queue its expected data.
    task automatic rd(logic [9:0] a, logic [31:0] exp, string tag, bit full = 1'b1);
        req_valid = 1'b1; req_write = 1'b0; req_full = full; req_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Issue a write.
    task automatic wr(logic [9:0] a, logic [31:0] d, bit full = 1'b1);
        req_valid = 1'b1; req_write = 1'b1; req_full = full;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Producer pushes one word.
    task automatic push(logic [31:0] d);
        in_push = 1'b1; in_data = d;
        @(negedge clk);
        in_push = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_full = 1'b1;
        req_addr = '0; req_wdata = '0; in_push = 1'b0; in_data = '0;
        in_noowner = 1'b0; ob_count = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 in_full after reset", {31'b0, in_full}, 32'h0);
        rd(10'h098, 32'h4000_0000, "R1 status after reset");
        rd(10'h09C, 32'h0, "R1 config after reset");
        rd(10'h090, 32'hFFFF_FFFF, "R1 peek after reset");

        // Three words, interrupt disabled, then enabled.
        push(32'hA0A0_0001); push(32'hB0B0_0002); push(32'hC0C0_0003);
        rd(10'h098, 32'h0000_0003, "R5 status count 3");
        rd(10'h09C, 32'h0000_0010, "R8 pending with data");
        check("R9 irq off while disabled", {31'b0, irq}, 32'h0);
        wr(10'h09C, 32'hFFFF_FFFF);
        rd(10'h09C, 32'h0000_0011, "R7 only enable bit written");
        check("R9 irq on", {31'b0, irq}, 32'h1);

        // Peek, pops across the range, alias above bit 7.
        rd(10'h090, 32'hA0A0_0001, "R4 peek head");
        rd(10'h090, 32'hA0A0_0001, "R4 peek does not remove");
        rd(10'h080, 32'hA0A0_0001, "R2 pop 0x80");
        rd(10'h08C, 32'hB0B0_0002, "R2 pop 0x8C");
        rd(10'h184, 32'hC0C0_0003, "R13 pop alias 0x184");
        rd(10'h098, 32'h4000_0000, "R5 status empty");
        check("R9 irq off when empty", {31'b0, irq}, 32'h0);
        rd(10'h088, 32'hFFFF_FFFF, "R3 empty pop sentinel");
        rd(10'h09C, 32'h0000_0401, "R3 underflow bit 10");
        rd(10'h098, 32'h4000_0000, "R3 nothing popped");
        wr(10'h09C, 32'h0000_0001);
        rd(10'h09C, 32'h0000_0001, "R10 config write clears errors");

        // Fill through the wrap point, overflow, no-owner.
        for (int i = 0; i < DEPTH; i++) push(32'h1000_0000 + i);
        rd(10'h098, 32'h8000_0008, "R5 status full");
        check("R5 in_full", {31'b0, in_full}, 32'h1);
        push(32'hBAD0_BAD0);
        rd(10'h09C, 32'h0000_0211, "R10 overflow bit 9");
        in_noowner = 1'b1; @(negedge clk); in_noowner = 1'b0;
        rd(10'h09C, 32'h0000_0311, "R10 noowner bit 8");
        for (int i = 0; i < DEPTH; i++) rd(10'h084, 32'h1000_0000 + i, "R2 drain order");
        rd(10'h090, 32'hFFFF_FFFF, "R4 peek sentinel after drain");
        rd(10'h09C, 32'h0000_0301, "R8 pending clear after drain");

        // Outbound status.
        ob_count = CW'(DEPTH);
        rd(10'h0B8, 32'h8000_0008, "R6 outbound full");
        ob_count = '0;
        rd(10'h0B8, 32'h4000_0000, "R6 outbound empty");
        ob_count = CW'(3);
        rd(10'h0B8, 32'h0000_0003, "R6 outbound count 3");

        // Sender and unsupported offsets.
        rd(10'h094, 32'h0, "R11 sender reads 0");
        wr(10'h094, 32'h0000_0000);
        rd(10'h0A4, 32'h0, "R11 unsupported reads 0");
        wr(10'h0A0, 32'h0000_0000);
        wr(10'h098, 32'h0000_0000);
        rd(10'h09C, 32'h0000_0301, "R11 writes left config");

        // Partial-width accesses.
        push(32'h5555_AAAA);
        rd(10'h080, 32'h0, "R12 partial read returns 0", 1'b0);
        rd(10'h098, 32'h0000_0001, "R12 partial read no pop");
        wr(10'h09C, 32'h0, 1'b0);
        rd(10'h09C, 32'h0000_0311, "R12 partial write ignored");
        check("R9 irq with data and enable", {31'b0, irq}, 32'h1);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0)
            check("missing responses", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule